// File: doc/BRIEF.md
# PWM Auto-Shutdown and Restart Controller

This block wraps a four-pin PWM generator (a free-running period counter with a duty compare) and guards it against fault conditions. Several external trip sources arrive as asynchronous digital levels, including comparator results that have already been turned into logic levels. While any synchronised source is high, every PWM pin is driven to its inactive level and a trip status flag is raised.

The flag has two release policies, chosen by a restart-mode bit. In automatic mode the flag follows the cause and drops by itself once every source has gone low. In latched mode it stays set until software writes it back to 0. Software may also write 1 to force a shutdown. A write is refused as a whole while any source is still active. Once the flag is clear, the pins come back only at the next period boundary, so there is never a partial first pulse. A one-cycle period-start pulse marks every counter wrap. Software can use it to tell when a full period has run before it enables the pins as outputs.

Top module: `pwm_trip_guard`

## Requirements
- R1: After reset, trip_flag and period_tick are 0, the restart mode is latched, and every pin sits at its inactive level until the first counter wrap.
- R2: The counter runs from 0 to `period` and then wraps to 0. While the pins are enabled, the raw drive is high when count < `duty`. pwm_a and pwm_d carry the raw drive, and pwm_b and pwm_c carry its complement.
- R3: pol_ac = 1 inverts pwm_a and pwm_c, and pol_bd = 1 inverts pwm_b and pwm_d. A value of 0 means active-high.
- R4: A trip source held high passes through a two-flop synchroniser. From the second clock edge after it is sampled, all pins are inactive: pwm_a and pwm_c equal pol_ac, and pwm_b and pwm_d equal pol_bd. trip_flag reads 1 from the third edge.
- R5: In automatic mode (restart bit 1), trip_flag returns to 0 one cycle after the synchronised cause has gone low.
- R6: In latched mode (restart bit 0), trip_flag stays 1 after the cause ends, until a write with wr_flag = 0 clears it.
- R7: A write (wr_en) in a cycle where any synchronised source is high changes neither trip_flag nor the restart mode.
- R8: A write with wr_flag = 1 sets trip_flag in the next cycle and forces the pins inactive, exactly as a trip does.
- R9: After trip_flag clears, the pins stay inactive until the first counter wrap, and they turn active only in a cycle where the count is 0.
- R10: period_tick is high for exactly the cycle in which the counter has just wrapped to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| trip_in | input | N_SRC | Asynchronous trip sources, active high |
| wr_en | input | 1 | Write strobe for the status/mode register |
| wr_flag | input | 1 | Value written to the trip flag (1 forces shutdown) |
| wr_restart | input | 1 | Value written to the restart mode (1 automatic, 0 latched) |
| period | input | W | Last count value of a period |
| duty | input | W | Count below which the raw drive is high |
| pol_ac | input | 1 | Pair A/C polarity, 1 = active-low |
| pol_bd | input | 1 | Pair B/D polarity, 1 = active-low |
| pwm_a | output | 1 | Pin A |
| pwm_b | output | 1 | Pin B |
| pwm_c | output | 1 | Pin C |
| pwm_d | output | 1 | Pin D |
| trip_flag | output | 1 | Shutdown status flag |
| period_tick | output | 1 | Period-start pulse |

## Verification
The main function is tried with three patterns, and each one separates a different fault.

- **Automatic mode, short trip.** A brief trip in automatic mode separates self-clearing from sticky behaviour. Checking the cycle just before the wrap also shows whether output resumes mid-period.
- **Latched mode with a refused write.** A trip in latched mode, with a release-and-switch-to-automatic write issued while the cause is live, shows whether the refused write leaked into the flag or the mode. A later software clear, checked mid-period, separates a boundary-aligned resume from an immediate one.
- **Forced shutdown with polarity changes.** A software-forced shutdown with both polarities flipped separates the inactive level after polarity from a plain zero.

Samples one and two cycles after a source rises pin down the synchroniser latency.

// File: rtl/pwm_trip_pkg.sv
package pwm_trip_pkg;

    typedef enum logic {
        MODE_LATCH = 1'b0,
        MODE_AUTO  = 1'b1
    } restart_mode_t;

    typedef struct packed {
        logic a;
        logic b;
        logic c;
        logic d;
    } pin_set_t;

    // Raw drive goes to A and D, its complement to B and C; disabled means
    // every pin at level 0 before the per-pair inversion.
    function automatic pin_set_t drive_pins(input logic en, input logic lvl,
                                            input logic inv_ac, input logic inv_bd);
        pin_set_t p;
        logic     hi;
        logic     lo;
        hi  = en & lvl;
        lo  = en & ~lvl;
        p.a = hi ^ inv_ac;
        p.c = lo ^ inv_ac;
        p.b = lo ^ inv_bd;
        p.d = hi ^ inv_bd;
        return p;
    endfunction

endpackage

// File: rtl/trip_sync.sv
module trip_sync #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] async_in,
    output logic [N-1:0] sync_out
);
    logic [N-1:0] stage1;
    logic [N-1:0] stage2;

    for (genvar i = 0; i < N; i++) begin : g_src
        always_ff @(posedge clk) begin
            if (rst) begin
                stage1[i] <= 1'b0;
                stage2[i] <= 1'b0;
            end else begin
                stage1[i] <= async_in[i];
                stage2[i] <= stage1[i];
            end
        end
    end

    assign sync_out = stage2;
endmodule

// File: rtl/pwm_timebase.sv
module pwm_timebase #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] period,
    input  logic [W-1:0] duty,
    output logic [W-1:0] cnt,
    output logic         wrap,
    output logic         tick,
    output logic         lvl
);
    assign wrap = (cnt >= period);
    assign lvl  = (cnt < duty);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt  <= '0;
            tick <= 1'b0;
        end else begin
            cnt  <= wrap ? '0 : cnt + 1'b1;
            tick <= wrap;
        end
    end
endmodule

// File: rtl/trip_state.sv
module trip_state
    import pwm_trip_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic cause,
    input  logic wr_en,
    input  logic wr_flag,
    input  logic wr_restart,
    input  logic wrap,
    output logic flag,
    output logic mode_auto,
    output logic out_en
);
    restart_mode_t mode_q;
    logic          run_q;
    logic          wr_ok;

    assign wr_ok     = wr_en & ~cause;
    assign mode_auto = (mode_q == MODE_AUTO);

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= MODE_LATCH;
        end else if (wr_ok) begin
            mode_q <= restart_mode_t'(wr_restart);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flag <= 1'b0;
        end else if (cause) begin
            flag <= 1'b1;
        end else if (wr_ok) begin
            flag <= wr_flag;
        end else if (mode_auto) begin
            flag <= 1'b0;
        end
    end

    // Output gate: dropped by any shutdown, re-armed only at a counter wrap.
    always_ff @(posedge clk) begin
        if (rst) begin
            run_q <= 1'b0;
        end else if (cause | flag) begin
            run_q <= 1'b0;
        end else if (wrap) begin
            run_q <= 1'b1;
        end
    end

    assign out_en = run_q & ~flag & ~cause;
endmodule

// File: rtl/pwm_trip_guard.sv
module pwm_trip_guard
    import pwm_trip_pkg::*;
#(
    parameter int W     = 8,
    parameter int N_SRC = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [N_SRC-1:0] trip_in,
    input  logic             wr_en,
    input  logic             wr_flag,
    input  logic             wr_restart,
    input  logic [W-1:0]     period,
    input  logic [W-1:0]     duty,
    input  logic             pol_ac,
    input  logic             pol_bd,
    output logic             pwm_a,
    output logic             pwm_b,
    output logic             pwm_c,
    output logic             pwm_d,
    output logic             trip_flag,
    output logic             period_tick
);
    logic [N_SRC-1:0] src_sync;
    logic             cause_any;
    logic [W-1:0]     cnt;
    logic             wrap;
    logic             lvl;
    logic             out_en;
    logic             mode_auto;
    pin_set_t         pins;

    trip_sync #(.N(N_SRC)) u_sync (
        .clk      (clk),
        .rst      (rst),
        .async_in (trip_in),
        .sync_out (src_sync)
    );

    assign cause_any = |src_sync;

    pwm_timebase #(.W(W)) u_timebase (
        .clk    (clk),
        .rst    (rst),
        .period (period),
        .duty   (duty),
        .cnt    (cnt),
        .wrap   (wrap),
        .tick   (period_tick),
        .lvl    (lvl)
    );

    trip_state u_state (
        .clk        (clk),
        .rst        (rst),
        .cause      (cause_any),
        .wr_en      (wr_en),
        .wr_flag    (wr_flag),
        .wr_restart (wr_restart),
        .wrap       (wrap),
        .flag       (trip_flag),
        .mode_auto  (mode_auto),
        .out_en     (out_en)
    );

    assign pins  = drive_pins(out_en, lvl, pol_ac, pol_bd);
    assign pwm_a = pins.a;
    assign pwm_b = pins.b;
    assign pwm_c = pins.c;
    assign pwm_d = pins.d;
endmodule

// File: rtl/pwm_trip_guard_chk.sv
module pwm_trip_guard_chk #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst,
    input logic         cause,
    input logic         flag,
    input logic         mode_auto,
    input logic         wr_en,
    input logic [W-1:0] cnt,
    input logic         out_en,
    input logic         tick,
    input logic [3:0]   pins,
    input logic [3:0]   idle_pins
);
    // R1: reset leaves flag and tick low
    assert_reset_state_R1: assert property (@(posedge clk)
        rst |=> (!flag && !tick));

    // R4: synchronised cause holds the pins at the inactive level
    assert_trip_pins_off_R4: assert property (@(posedge clk) disable iff (rst)
        cause |-> (pins == idle_pins));

    // R4: synchronised cause raises the flag next cycle
    assert_trip_sets_flag_R4: assert property (@(posedge clk) disable iff (rst)
        cause |=> flag);

    // R5: automatic mode releases the flag once the cause is gone
    assert_auto_release_R5: assert property (@(posedge clk) disable iff (rst)
        (mode_auto && flag && !cause && !wr_en) |=> !flag);

    // R6: latched mode holds the flag without a write
    assert_latched_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (!mode_auto && flag && !wr_en) |=> flag);

    // R7: writes while the cause is live change nothing
    assert_write_refused_R7: assert property (@(posedge clk) disable iff (rst)
        (cause && wr_en) |=> (flag && $stable(mode_auto)));

    // R9: output resumes only at count 0
    assert_resume_at_wrap_R9: assert property (@(posedge clk) disable iff (rst)
        $rose(out_en) |-> (cnt == '0));

    // R9: pins stay inactive while output is gated off
    assert_gated_pins_R9: assert property (@(posedge clk) disable iff (rst)
        !out_en |-> (pins == idle_pins));

    // R10: tick only marks the cycle at count 0
    assert_tick_at_zero_R10: assert property (@(posedge clk) disable iff (rst)
        tick |-> (cnt == '0));
endmodule

bind pwm_trip_guard pwm_trip_guard_chk #(.W(W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .cause     (cause_any),
    .flag      (trip_flag),
    .mode_auto (mode_auto),
    .wr_en     (wr_en),
    .cnt       (cnt),
    .out_en    (out_en),
    .tick      (period_tick),
    .pins      ({pwm_a, pwm_b, pwm_c, pwm_d}),
    .idle_pins ({pol_ac, pol_bd, pol_ac, pol_bd})
);

// File: tb/pwm_trip_guard_test.sv
`timescale 1ns/1ps
module pwm_trip_guard_test;
    localparam int W  = 8;
    localparam int NS = 3;
    localparam int P  = 9;
    localparam int D  = 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [NS-1:0] trip_in = '0;
    logic          wr_en = 1'b0;
    logic          wr_flag = 1'b0;
    logic          wr_restart = 1'b0;
    logic [W-1:0]  period = W'(P);
    logic [W-1:0]  duty = W'(D);
    logic          pol_ac = 1'b0;
    logic          pol_bd = 1'b0;
    logic          pwm_a, pwm_b, pwm_c, pwm_d, trip_flag, period_tick;

    pwm_trip_guard #(.W(W), .N_SRC(NS)) uut (
        .clk(clk), .rst(rst), .trip_in(trip_in), .wr_en(wr_en),
        .wr_flag(wr_flag), .wr_restart(wr_restart), .period(period),
        .duty(duty), .pol_ac(pol_ac), .pol_bd(pol_bd), .pwm_a(pwm_a),
        .pwm_b(pwm_b), .pwm_c(pwm_c), .pwm_d(pwm_d),
        .trip_flag(trip_flag), .period_tick(period_tick)
    );

    always #2 clk = ~clk;

    // Cycles since reset release; equals the expected counter value mod P+1.
    int cyc = 0;
    always @(posedge clk) cyc <= rst ? 0 : cyc + 1;

    typedef struct {
        logic [3:0] pins;
        logic       flag;
        logic       tick;
        string      tag;
    } item_t;

    item_t q[$];
    int    n_chk = 0;
    int    n_bad = 0;
    bit    done  = 0;

    function automatic logic [3:0] exp_pins(bit en);
        logic lvl, hi, lo;
        lvl = (cyc % (P + 1)) < D;
        hi  = en & lvl;
        lo  = en & ~lvl;
        return {hi ^ pol_ac, lo ^ pol_bd, lo ^ pol_ac, hi ^ pol_bd};
    endfunction

    task automatic push(bit en, bit flg, string tag);
        item_t it;
        it.pins = exp_pins(en);
        it.flag = flg;
        it.tick = (cyc > 0) && (cyc % (P + 1) == 0);
        it.tag  = tag;
        q.push_back(it);
    endtask

    task automatic go_to(int n);
        while (cyc < n) @(negedge clk);
    endtask

    task automatic expect_at(int n, bit en, bit flg, string tag);
        go_to(n);
        push(en, flg, tag);
    endtask

    task automatic reg_write(bit f, bit r);
        wr_en = 1'b1; wr_flag = f; wr_restart = r;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // Monitor: compares queued expectations just after each falling edge.
    initial begin
        forever begin
            @(negedge clk);
            #1;
            while (q.size() > 0) begin
                item_t it;
                logic [3:0] act;
                it  = q.pop_front();
                act = {pwm_a, pwm_b, pwm_c, pwm_d};
                n_chk++;
                if (act !== it.pins || trip_flag !== it.flag || period_tick !== it.tick) begin
                    n_bad++;
                    $display("FAIL %s @cyc %0d: pins=%b flag=%b tick=%b, expected pins=%b flag=%b tick=%b",
                             it.tag, cyc, act, trip_flag, period_tick, it.pins, it.flag, it.tick);
                end
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        push(0, 0, "R1 in reset");
        @(negedge clk);
        rst = 1'b0;
        expect_at(5, 0, 0, "R1 held through first period");
        expect_at(10, 1, 0, "R2 R10 enabled at first wrap");
        expect_at(16, 1, 0, "R2 complement phase");
        go_to(20); pol_ac = 1'b1;
        expect_at(21, 1, 0, "R3 pair A/C inverted");
        go_to(24); pol_ac = 1'b0; pol_bd = 1'b1;
        expect_at(26, 1, 0, "R3 pair B/D inverted");
        go_to(28); pol_bd = 1'b0;
        go_to(30); reg_write(1'b0, 1'b1);
        go_to(32); trip_in[0] = 1'b1;
        expect_at(33, 1, 0, "R4 not yet through synchroniser");
        expect_at(34, 0, 0, "R4 pins off");
        expect_at(35, 0, 1, "R4 flag set");
        expect_at(36, 0, 1, "R4 flag while cause");
        trip_in[0] = 1'b0;
        expect_at(38, 0, 1, "R5 flag until sync cause low");
        expect_at(39, 0, 0, "R5 auto release, R9 still gated");
        expect_at(40, 1, 0, "R9 resume at wrap");
        go_to(42); reg_write(1'b0, 1'b0);
        go_to(52); trip_in[1] = 1'b1;
        expect_at(54, 0, 0, "R4 second source");
        expect_at(55, 0, 1, "R4 flag second source");
        reg_write(1'b0, 1'b1);
        expect_at(56, 0, 1, "R7 write refused");
        trip_in[1] = 1'b0;
        expect_at(60, 0, 1, "R6 R7 latched, mode unchanged");
        expect_at(61, 0, 1, "R6 latched hold");
        go_to(62); reg_write(1'b0, 1'b0);
        expect_at(63, 0, 0, "R6 software clear");
        expect_at(65, 0, 0, "R9 no mid-period resume");
        expect_at(70, 1, 0, "R9 resume after clear");
        go_to(72); reg_write(1'b1, 1'b0);
        expect_at(73, 0, 1, "R8 forced shutdown");
        go_to(75); pol_ac = 1'b1; pol_bd = 1'b1;
        expect_at(76, 0, 1, "R8 R3 inactive level after polarity");
        go_to(78); pol_ac = 1'b0; pol_bd = 1'b0;
        expect_at(80, 0, 1, "R8 forced state held");
        go_to(82); reg_write(1'b0, 1'b0);
        expect_at(83, 0, 0, "R8 cleared");
        expect_at(90, 1, 0, "R9 R10 resume at wrap");
        expect_at(95, 1, 0, "R2 low phase");
        repeat (3) @(negedge clk);
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule